// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block generates the coil drive pattern for a four-coil unipolar stepper motor, and can also drive a three-winding variable-reluctance motor from the same outputs. It contains its own step-rate divider. The divider value gives the number of clock cycles in each step. To convert a target speed, use steps per second = RPM × steps per revolution / 60, then divide the clock frequency by that figure.

A mode input selects one of four excitation tables: single-coil wave drive, two-coil full step, eight-step half step, or three-phase reluctance drive. One phase index is shared by all tables. Reversing direction or switching mode therefore continues from the current rotor position and does not restart the sequence. Changes on the mode and direction inputs take effect only at a step boundary. A single-cycle pulse marks each step.

Top module: `stepper_phase_seq`

## Requirements
- R1: After reset the phase index is 0, the active table is wave drive, the divider count is 0 and `step_done` is 0. While `enable` is low, `coil` is 4'b0000.
- R2: Wave drive (`mode`=0, length 4) energises one coil per index, from index 0 to 3: 4'b0001, 4'b0010, 4'b0100, 4'b1000. The bits are `coil[0]`=coil 1a, `coil[1]`=coil 2a, `coil[2]`=coil 1b, `coil[3]`=coil 2b.
- R3: Full step (`mode`=1, length 4) energises two adjacent coils per index, from index 0 to 3: 4'b1001, 4'b0011, 4'b0110, 4'b1100.
- R4: Half step (`mode`=2, length 8) alternates one coil and two coils, from index 0 to 7: 4'b0001, 4'b0011, 4'b0010, 4'b0110, 4'b0100, 4'b1100, 4'b1000, 4'b1001.
- R5: Reluctance mode (`mode`=3, length 3) energises one winding per index, from index 0 to 2: 4'b0001, 4'b0010, 4'b0100. `coil[3]` is always 0 in this mode.
- R6: At each step, `dir`=0 increments the index and `dir`=1 decrements it, wrapping modulo the length of the active table.
- R7: Driving `enable` low forces `coil` to 0, clears the divider count and stops stepping. The phase index is kept, so on re-enable the pattern resumes at the same index.
- R8: `mode` is sampled only at a step boundary. At that edge the index is first reduced modulo the new table length and then advanced by one step in the direction given by `dir`.
- R9: While enabled, a step happens every `rate_div` clock cycles. A `rate_div` of 0 is treated as 1. The first step comes on the `rate_div`-th rising edge after `enable` goes high.
- R10: `step_done` is high for exactly the one cycle in which the new pattern first appears on `coil`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low de-energises all coils |
| dir | input | 1 | Step direction: 0 forward, 1 reverse |
| mode | input | 2 | Excitation table: 0 wave, 1 full step, 2 half step, 3 reluctance |
| rate_div | input | DIV_W | Clock cycles per step (0 behaves as 1) |
| coil | output | 4 | Coil enables |
| step_done | output | 1 | One-cycle pulse when the pattern advances |

## Verification
A mode change and a direction reversal can land on the same step edge. The reduction of the index into the new table and the move in the new direction then happen in one update. The bench provokes this in directed runs (half step into reversed reluctance drive) and in a long random run that changes `mode`, `dir`, `enable` and `rate_div` at arbitrary cycles, including edges where the divider expires. A behavioural model compares `coil` and `step_done` on every cycle. It shows that the step lands on the index reduced into the new table, and that input changes between steps leave the outputs untouched.

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             dir,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] rate_div,
  output logic [3:0]       coil,
  output logic             step_done
);
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {M_WAVE = 2'd0, M_FULL = 2'd1, M_HALF = 2'd2, M_VR = 2'd3} mode_t;

  function automatic logic [3:0] seq_len(input mode_t m);
    case (m)
      M_HALF:  seq_len = 4'd8;
      M_VR:    seq_len = 4'd3;
      default: seq_len = 4'd4;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] fold(input logic [IDX_W-1:0] i, input mode_t m);
    case (m)
      M_HALF: fold = i;
      M_VR: begin
        case (i)
          3'd3, 3'd6: fold = 3'd0;
          3'd4, 3'd7: fold = 3'd1;
          3'd5:       fold = 3'd2;
          default:    fold = i;
        endcase
      end
      default: fold = {1'b0, i[1:0]};
    endcase
  endfunction

  function automatic logic [3:0] pattern(input mode_t m, input logic [IDX_W-1:0] i);
    case (m)
      M_WAVE: pattern = 4'b0001 << i[1:0];
      M_FULL: begin
        case (i[1:0])
          2'd0: pattern = 4'b1001;
          2'd1: pattern = 4'b0011;
          2'd2: pattern = 4'b0110;
          default: pattern = 4'b1100;
        endcase
      end
      M_HALF: begin
        if (!i[0]) pattern = 4'b0001 << i[2:1];
        else if (i[2:1] == 2'd3) pattern = 4'b1001;
        else pattern = 4'b0011 << i[2:1];
      end
      default: pattern = (i < 3'd3) ? (4'b0001 << i[1:0]) : 4'b0000;
    endcase
  endfunction

  logic [DIV_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  mode_t            cur_mode;

  wire [DIV_W-1:0] lim  = (rate_div == '0) ? DIV_W'(1) : rate_div;
  wire             tick = enable && (cnt >= lim - DIV_W'(1));

  wire mode_t            nmode = mode_t'(mode);
  wire [3:0]             nlen  = seq_len(nmode);
  wire [IDX_W-1:0]       base  = fold(idx, nmode);
  wire [IDX_W-1:0]       last  = IDX_W'(nlen - 4'd1);
  wire [IDX_W-1:0]       nidx  = dir ? ((base == '0) ? last : base - 3'd1)
                                     : ((base == last) ? '0 : base + 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      idx       <= '0;
      cur_mode  <= M_WAVE;
      step_done <= 1'b0;
    end else begin
      step_done <= tick;
      if (!enable) begin
        cnt <= '0;
      end else if (tick) begin
        cnt      <= '0;
        cur_mode <= nmode;
        idx      <= nidx;
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  assign coil = enable ? pattern(cur_mode, idx) : 4'b0000;

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, idx} < seq_len(cur_mode));

  // R2
  wave_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cur_mode == M_WAVE) |-> $onehot(coil));

  // R3
  full_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cur_mode == M_FULL) |-> ($countones(coil) == 2));

  // R5
  vr_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cur_mode == M_VR) |-> ($onehot(coil) && !coil[3]));

  // R10
  done_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> $past(enable));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(enable) && !enable) |-> ($stable(idx) && !step_done && coil == 4'b0000));
endmodule

// File: tb/test_stepper_phase_seq.sv
`timescale 1ns/1ps
module test_stepper_phase_seq;
  localparam int DIV_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic dir = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [DIV_W-1:0] rate_div = 16'd3;
  logic [3:0] coil;
  logic step_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  stepper_phase_seq #(.DIV_W(DIV_W)) i_stepper_phase_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dir(dir), .mode(mode),
    .rate_div(rate_div), .coil(coil), .step_done(step_done)
  );

  int q_wave[$] = '{1, 2, 4, 8};
  int q_full[$] = '{9, 3, 6, 12};
  int q_half[$] = '{1, 3, 2, 6, 4, 12, 8, 9};
  int q_vr[$]   = '{1, 2, 4};

  function automatic int tab_len(int m);
    if (m == 2) return 8;
    if (m == 3) return 3;
    return 4;
  endfunction

  function automatic int tab_val(int m, int i);
    case (m)
      0: return q_wave[i];
      1: return q_full[i];
      2: return q_half[i];
      default: return q_vr[i];
    endcase
  endfunction

  int m_cnt = 0, m_idx = 0, m_mode = 0;
  bit m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_idx = 0; m_mode = 0; m_done = 0;
    end else begin
      int lim;
      m_done = 0;
      lim = (rate_div == 0) ? 1 : int'(rate_div);
      if (!enable) m_cnt = 0;
      else if (m_cnt >= lim - 1) begin
        int l, b;
        m_cnt = 0;
        m_mode = int'(mode);
        l = tab_len(m_mode);
        b = m_idx % l;
        m_idx = dir ? (b + l - 1) % l : (b + 1) % l;
        m_done = 1;
      end else m_cnt = m_cnt + 1;
    end
  end

  function automatic string mode_req(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int ec;
      ec = enable ? tab_val(m_mode, m_idx) : 0;
      checks++;
      if (int'(coil) != ec) begin
        errors++;
        $display("FAIL %s/R7/R8 cycle model: coil=%b expected=%b", enable ? mode_req(m_mode) : "R7", coil, 4'(ec));
      end
      checks++;
      if (step_done != m_done) begin
        errors++;
        $display("FAIL R10/R9 cycle model: step_done=%0b expected=%0b", step_done, m_done);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_step(output int n, output logic [3:0] pat);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!step_done && n < 1000);
    pat = coil;
  endtask

  task automatic expect_step(string req, int exp);
    int n;
    logic [3:0] p;
    wait_step(n, p);
    check(req, int'(p), exp);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [3:0] p;
    repeat (3) @(negedge clk);
    check("R1 coil in reset", int'(coil), 0);
    check("R1 step_done in reset", int'(step_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 coil disabled after reset", int'(coil), 0);
    enable = 1'b1;
    @(negedge clk);
    check("R2 wave index 0", int'(coil), 4'b0001);
    expect_step("R2 wave 1", 4'b0010);
    wait_step(n, p);
    check("R2 wave 2", int'(p), 4'b0100);
    check("R9 period 3", n, 3);
    expect_step("R2 wave 3", 4'b1000);
    expect_step("R6 forward wrap", 4'b0001);
    dir = 1'b1;
    expect_step("R6 reverse wrap", 4'b1000);
    expect_step("R6 reverse", 4'b0100);
    enable = 1'b0;
    @(negedge clk);
    check("R7 coils off", int'(coil), 0);
    repeat (10) @(negedge clk);
    check("R7 no step while off", int'(step_done), 0);
    enable = 1'b1;
    @(negedge clk);
    check("R7 resume same index", int'(coil), 4'b0100);
    mode = 2'd1; dir = 1'b0;
    @(negedge clk);
    check("R8 mode not yet applied", int'(coil), 4'b0100);
    expect_step("R8 R3 full index 3", 4'b1100);
    expect_step("R3 full 0", 4'b1001);
    expect_step("R3 full 1", 4'b0011);
    mode = 2'd2;
    expect_step("R4 half 2", 4'b0010);
    expect_step("R4 half 3", 4'b0110);
    expect_step("R4 half 4", 4'b0100);
    expect_step("R4 half 5", 4'b1100);
    expect_step("R4 half 6", 4'b1000);
    expect_step("R4 half 7", 4'b1001);
    expect_step("R4 half wrap", 4'b0001);
    mode = 2'd3; dir = 1'b1;
    expect_step("R5 R8 vr reverse 2", 4'b0100);
    expect_step("R5 vr 1", 4'b0010);
    expect_step("R5 vr 0", 4'b0001);
    expect_step("R5 R6 vr wrap", 4'b0100);
    rate_div = 16'd0;
    wait_step(n, p);
    wait_step(n, p);
    check("R9 div 0 acts as 1", n, 1);
    rate_div = 16'd1;
    wait_step(n, p);
    wait_step(n, p);
    check("R9 div 1", n, 1);
    rate_div = 16'd5;
    wait_step(n, p);
    wait_step(n, p);
    check("R9 div 5", n, 5);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) dir = ~dir;
      if ($urandom_range(0, 40) == 0) enable = ~enable;
      if ($urandom_range(0, 60) == 0) rate_div = 16'($urandom_range(0, 4));
    end
    @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule